// File: doc/BRIEF.md
# Display Controller Register Window

This block sits behind a 4 KiB memory-mapped region of a display controller and routes each bus request into one of three sub-windows. The first relays accesses to the legacy byte-wide VGA I/O ports. Any access wider than a byte is broken into consecutive byte accesses, lowest byte first, so an index/data port pair can be loaded with one word store. The second sub-window reaches an indexed file of extended-mode registers. The block derives the register index from the address, loads its index register, and then issues one 16-bit data access.

The third sub-window is a small extension bank. It reports its own size and owns the framebuffer byte-order flag. The flag changes only when one of two magic words is written. Every other request completes with a single response pulse. Unmapped reads return zero and unmapped writes do nothing. A parameter removes the extension bank, and the revision output reports whether the bank is present.

The bus side takes one request at a time. `req_ready` is high only when the block is idle, and `resp_valid` pulses once per accepted request. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. The size field is 0 for byte, 1 for 16-bit and 2 (or 3) for 32-bit.

Top module: `disp_regwin`

## Requirements
- R1: After reset, `big_endian_fb` is 0, `xreg_index` is 0, `req_ready` is 1, `resp_valid` is 0, and no port or register strobe is active.
- R2: A byte access at offset 0x400+k (k < 0x20) produces exactly one port strobe, with `port_addr` = 0x3C0+k.
- R3: A legacy write of 2 or 4 bytes issues one port write per cycle on consecutive port addresses. Byte 0 of the write data goes first to the lowest port. The response follows in the cycle after the last strobe, so the response latency is bytes+1 cycles after acceptance.
- R4: A legacy read of 2 or 4 bytes places the byte read from port N+j into bits 8j+7:8j of `resp_rdata`. The remaining upper bits are zero.
- R5: Any access at offset 0x500+k (k < 0x16) first sets `xreg_index` to k>>1. In the next cycle it issues exactly one 16-bit data strobe with that index and `xreg_wdata` = write data bits 15:0, whatever the request size. The response follows one cycle after the strobe.
- R6: A read in the extended-register window returns `xreg_rdata` in bits 15:0 and zero above. `xreg_index` keeps its value after the access.
- R7: A 32-bit read at offset 0x600 returns 8.
- R8: A 32-bit read at offset 0x604 returns 0xBEBEBEBE while `big_endian_fb` is 1, and 0x1E1E1E1E while it is 0.
- R9: A 32-bit write at 0x604 sets `big_endian_fb` when the data is 0xBEBEBEBE and clears it when the data is 0x1E1E1E1E. Any other data leaves the flag unchanged.
- R10: In the extension bank, these accesses read zero and never change the flag: non-32-bit accesses, and any offset other than 0 and 4.
- R11: Offsets outside all sub-windows read zero, issue no strobe, and respond in the first cycle after acceptance. `resp_valid` lasts one cycle and is followed by `req_ready`.
- R12: With the extension bank disabled, its range behaves as in R11, `big_endian_fb` stays 0 and `revision` is 1. With the bank enabled, `revision` is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset inside the window |
| req_size | input | 2 | 0 byte, 1 16-bit, 2/3 32-bit |
| req_wdata | input | 32 | Write data, little-endian lanes |
| req_ready | output | 1 | Idle, request can be taken |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 32 | Read data, valid with resp_valid |
| port_rd | output | 1 | Legacy port read strobe |
| port_wr | output | 1 | Legacy port write strobe |
| port_addr | output | 16 | Legacy port address |
| port_wdata | output | 8 | Legacy port write byte |
| port_rdata | input | 8 | Legacy port read byte, same cycle |
| xreg_rd | output | 1 | Extended register read strobe |
| xreg_wr | output | 1 | Extended register write strobe |
| xreg_index | output | 16 | Extended register index register |
| xreg_wdata | output | 16 | Extended register write data |
| xreg_rdata | input | 16 | Extended register read data, same cycle |
| big_endian_fb | output | 1 | Framebuffer byte-order flag |
| revision | output | 8 | 2 with extension bank, 1 without |

## Verification
A corrupted byte counter or port base shows up at the port strobes in the same cycle: the wrong address, the wrong byte lane, or one strobe too many or too few. A bad lane in the read buffer appears in the response a single cycle after the last strobe. A stale index register is exposed in the very cycle of the data strobe, because the index is latched one cycle earlier. A byte-order flag that takes a non-magic value shows immediately at `big_endian_fb` and on the next read of register 1.

// File: rtl/disp_regwin_pkg.sv
package disp_regwin_pkg;

    localparam int LEG_BASE  = 'h400;
    localparam int LEG_SPAN  = 'h20;
    localparam int EXT_BASE  = 'h500;
    localparam int EXT_SPAN  = 'h16;
    localparam int XB_BASE   = 'h600;
    localparam int XB_SPAN   = 8;
    localparam logic [15:0] PORT_BASE = 16'h03C0;
    localparam logic [31:0] ORDER_BIG = 32'hBEBE_BEBE;
    localparam logic [31:0] ORDER_LIT = 32'h1E1E_1E1E;

    typedef enum logic [1:0] {WIN_NONE, WIN_LEG, WIN_EXT, WIN_XB} win_e;
    typedef enum logic [1:0] {ST_IDLE, ST_LEG, ST_EXT, ST_DONE} st_e;

    typedef struct packed {
        win_e       win;
        logic [7:0] off;
    } hit_t;

    function automatic logic [1:0] last_byte(input logic [1:0] sz);
        case (sz)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/disp_regwin_decode.sv
module disp_regwin_decode
    import disp_regwin_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter bit XB_EN  = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output hit_t              hit
);
    localparam logic [ADDR_W-1:0] L_LO = ADDR_W'(LEG_BASE);
    localparam logic [ADDR_W-1:0] L_HI = ADDR_W'(LEG_BASE + LEG_SPAN);
    localparam logic [ADDR_W-1:0] E_LO = ADDR_W'(EXT_BASE);
    localparam logic [ADDR_W-1:0] E_HI = ADDR_W'(EXT_BASE + EXT_SPAN);
    localparam logic [ADDR_W-1:0] X_LO = ADDR_W'(XB_BASE);
    localparam logic [ADDR_W-1:0] X_HI = ADDR_W'(XB_BASE + XB_SPAN);

    always_comb begin
        hit.win = WIN_NONE;
        hit.off = 8'd0;
        if (addr >= L_LO && addr < L_HI) begin
            hit.win = WIN_LEG;
            hit.off = 8'(addr - L_LO);
        end else if (addr >= E_LO && addr < E_HI) begin
            hit.win = WIN_EXT;
            hit.off = 8'(addr - E_LO);
        end else if (XB_EN && addr >= X_LO && addr < X_HI) begin
            hit.win = WIN_XB;
            hit.off = 8'(addr - X_LO);
        end
    end
endmodule

// File: rtl/disp_regwin_xbank.sv
module disp_regwin_xbank
    import disp_regwin_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        acc,
    input  logic        wr,
    input  logic [2:0]  off,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        big_end
);
    always_ff @(posedge clk) begin
        if (rst) begin
            big_end <= 1'b0;
        end else if (acc && wr && off == 3'd4) begin
            if (wdata == ORDER_BIG)
                big_end <= 1'b1;
            else if (wdata == ORDER_LIT)
                big_end <= 1'b0;
        end
    end

    always_comb begin
        case (off)
            3'd0:    rdata = 32'(XB_SPAN);
            3'd4:    rdata = big_end ? ORDER_BIG : ORDER_LIT;
            default: rdata = 32'd0;
        endcase
    end
endmodule

// File: rtl/disp_regwin.sv
module disp_regwin
    import disp_regwin_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter bit XB_EN  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              req_ready,
    output logic              resp_valid,
    output logic [31:0]       resp_rdata,
    output logic              port_rd,
    output logic              port_wr,
    output logic [15:0]       port_addr,
    output logic [7:0]        port_wdata,
    input  logic [7:0]        port_rdata,
    output logic              xreg_rd,
    output logic              xreg_wr,
    output logic [15:0]       xreg_index,
    output logic [15:0]       xreg_wdata,
    input  logic [15:0]       xreg_rdata,
    output logic              big_endian_fb,
    output logic [7:0]        revision
);
    st_e         st;
    hit_t        hit;
    logic        wr_q;
    logic [31:0] wbuf;
    logic [31:0] rbuf;
    logic [15:0] pbase;
    logic [1:0]  bidx;
    logic [1:0]  blast;
    logic [15:0] xidx;
    logic        accept;
    logic        xb_acc;
    logic [31:0] xb_rdata;

    assign accept = req_valid && req_ready;
    assign xb_acc = accept && hit.win == WIN_XB && req_size[1];

    disp_regwin_decode #(.ADDR_W(ADDR_W), .XB_EN(XB_EN)) u_dec (
        .addr (req_addr),
        .hit  (hit)
    );

    generate
        if (XB_EN) begin : g_xb
            disp_regwin_xbank u_xb (
                .clk     (clk),
                .rst     (rst),
                .acc     (xb_acc),
                .wr      (req_write),
                .off     (hit.off[2:0]),
                .wdata   (req_wdata),
                .rdata   (xb_rdata),
                .big_end (big_endian_fb)
            );
            assign revision = 8'd2;
        end else begin : g_no_xb
            assign xb_rdata      = 32'd0;
            assign big_endian_fb = 1'b0;
            assign revision      = 8'd1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            wr_q  <= 1'b0;
            wbuf  <= 32'd0;
            rbuf  <= 32'd0;
            pbase <= 16'd0;
            bidx  <= 2'd0;
            blast <= 2'd0;
            xidx  <= 16'd0;
        end else begin
            case (st)
                ST_IDLE: if (accept) begin
                    wr_q  <= req_write;
                    wbuf  <= req_wdata;
                    bidx  <= 2'd0;
                    blast <= last_byte(req_size);
                    pbase <= PORT_BASE + 16'(hit.off);
                    rbuf  <= (xb_acc && !req_write) ? xb_rdata : 32'd0;
                    case (hit.win)
                        WIN_LEG: st <= ST_LEG;
                        WIN_EXT: begin
                            st   <= ST_EXT;
                            xidx <= 16'(hit.off >> 1);
                        end
                        default: st <= ST_DONE;
                    endcase
                end
                ST_LEG: begin
                    if (!wr_q)
                        rbuf[{bidx, 3'b000} +: 8] <= port_rdata;
                    if (bidx == blast)
                        st <= ST_DONE;
                    else
                        bidx <= bidx + 2'd1;
                end
                ST_EXT: begin
                    if (!wr_q)
                        rbuf[15:0] <= xreg_rdata;
                    st <= ST_DONE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready  = (st == ST_IDLE);
    assign resp_valid = (st == ST_DONE);
    assign resp_rdata = rbuf;
    assign port_rd    = (st == ST_LEG) && !wr_q;
    assign port_wr    = (st == ST_LEG) && wr_q;
    assign port_addr  = pbase + 16'(bidx);
    assign port_wdata = wbuf[{bidx, 3'b000} +: 8];
    assign xreg_rd    = (st == ST_EXT) && !wr_q;
    assign xreg_wr    = (st == ST_EXT) && wr_q;
    assign xreg_index = xidx;
    assign xreg_wdata = wbuf[15:0];
endmodule

// File: rtl/disp_regwin_chk.sv
module disp_regwin_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic [31:0]       req_wdata,
    input logic              resp_valid,
    input logic              port_rd,
    input logic              port_wr,
    input logic [15:0]       port_addr,
    input logic              xreg_rd,
    input logic              xreg_wr,
    input logic [15:0]       xreg_index,
    input logic              big_endian_fb
);
    // R2 / R11: at most one strobe or the response per cycle
    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({port_rd, port_wr, xreg_rd, xreg_wr, resp_valid}));

    // R2: legacy strobes stay within the relayed port range
    p_port_range_r2: assert property (@(posedge clk) disable iff (rst)
        (port_rd || port_wr) |-> (port_addr >= 16'h03C0 && port_addr <= 16'h03E2));

    // R5: data strobes only carry a valid extended index
    p_xidx_range_r5: assert property (@(posedge clk) disable iff (rst)
        (xreg_rd || xreg_wr) |-> xreg_index <= 16'd10);

    // R11: single-cycle response followed by idle
    p_resp_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> (!resp_valid && req_ready));

    // R9: flag moves only after an accepted 32-bit write to register 1
    p_flag_gate_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(big_endian_fb) |-> $past(req_valid && req_ready && req_write &&
            req_size[1] && req_addr == ADDR_W'('h604)));

    // R9: flag rises only on the big-endian magic word
    p_flag_magic_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(big_endian_fb) |-> $past(req_wdata) == 32'hBEBE_BEBE);
endmodule

bind disp_regwin disp_regwin_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_size      (req_size),
    .req_wdata     (req_wdata),
    .resp_valid    (resp_valid),
    .port_rd       (port_rd),
    .port_wr       (port_wr),
    .port_addr     (port_addr),
    .xreg_rd       (xreg_rd),
    .xreg_wr       (xreg_wr),
    .xreg_index    (xreg_index),
    .big_endian_fb (big_endian_fb)
);

// File: tb/disp_regwin_test.sv
module disp_regwin_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = 12'd0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_wdata = 32'd0;

    logic        req_ready, resp_valid, port_rd, port_wr, xreg_rd, xreg_wr, big_endian_fb;
    logic [31:0] resp_rdata;
    logic [15:0] port_addr, xreg_index, xreg_wdata;
    logic [7:0]  port_wdata, port_rdata, revision;
    logic [15:0] xreg_rdata;

    logic        n_ready, n_resp, n_prd, n_pwr, n_xrd, n_xwr, n_be;
    logic [31:0] n_rdata;
    logic [15:0] n_paddr, n_xidx, n_xwd;
    logic [7:0]  n_pwd, n_rev;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    assign port_rdata = port_addr[7:0] ^ 8'h5A;
    assign xreg_rdata = 16'hA000 | xreg_index;

    disp_regwin uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .port_rd(port_rd), .port_wr(port_wr), .port_addr(port_addr),
        .port_wdata(port_wdata), .port_rdata(port_rdata),
        .xreg_rd(xreg_rd), .xreg_wr(xreg_wr), .xreg_index(xreg_index),
        .xreg_wdata(xreg_wdata), .xreg_rdata(xreg_rdata),
        .big_endian_fb(big_endian_fb), .revision(revision)
    );

    disp_regwin #(.XB_EN(1'b0)) uut_nx (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .req_ready(n_ready), .resp_valid(n_resp), .resp_rdata(n_rdata),
        .port_rd(n_prd), .port_wr(n_pwr), .port_addr(n_paddr),
        .port_wdata(n_pwd), .port_rdata(n_paddr[7:0] ^ 8'h5A),
        .xreg_rd(n_xrd), .xreg_wr(n_xwr), .xreg_index(n_xidx),
        .xreg_wdata(n_xwd), .xreg_rdata(16'hA000 | n_xidx),
        .big_endian_fb(n_be), .revision(n_rev)
    );

    // observation record of the last access
    int          lat;
    int          n_ps;
    logic [15:0] ps_addr [4];
    logic [7:0]  ps_data [4];
    logic        ps_wr;
    int          n_xs;
    logic [15:0] xs_idx;
    logic [15:0] xs_wd;
    logic        xs_wr;
    logic [31:0] rd;
    logic [31:0] nrd;

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic acc(input logic [11:0] a, input logic [1:0] sz,
                       input logic w, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_write = w; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0; n_ps = 0; n_xs = 0; ps_wr = 1'b0; xs_wr = 1'b0;
        xs_idx = 16'hFFFF; xs_wd = 16'hFFFF; rd = 32'hDEAD_DEAD; nrd = 32'hDEAD_DEAD;
        for (int c = 1; c <= 20; c++) begin
            if (port_rd || port_wr) begin
                if (n_ps < 4) begin
                    ps_addr[n_ps] = port_addr;
                    ps_data[n_ps] = port_wdata;
                end
                ps_wr = port_wr;
                n_ps++;
            end
            if (xreg_rd || xreg_wr) begin
                xs_idx = xreg_index;
                xs_wd  = xreg_wdata;
                xs_wr  = xreg_wr;
                n_xs++;
            end
            if (resp_valid) begin
                lat = c;
                rd  = resp_rdata;
                nrd = n_rdata;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk("R1 flag", 32'(big_endian_fb), 32'd0);
        chk("R1 index", 32'(xreg_index), 32'd0);
        chk("R1 ready", 32'(req_ready), 32'd1);
        chk("R1 resp", 32'(resp_valid), 32'd0);
        chk("R1 strobes", 32'({port_rd, port_wr, xreg_rd, xreg_wr}), 32'd0);
    endtask

    task automatic t_leg_byte;
        acc(12'h405, 2'd0, 1'b1, 32'h0000_00AB);
        chk("R2 count", 32'(n_ps), 32'd1);
        chk("R2 addr", 32'(ps_addr[0]), 32'h3C5);
        chk("R2 data", 32'(ps_data[0]), 32'hAB);
        chk("R2 latency", 32'(lat), 32'd2);
        acc(12'h41F, 2'd0, 1'b0, 32'd0);
        chk("R2 top addr", 32'(ps_addr[0]), 32'h3DF);
        chk("R2 top read", rd, 32'h0000_0085);
    endtask

    task automatic t_leg_split_write;
        acc(12'h414, 2'd1, 1'b1, 32'h0000_1234);
        chk("R3 count", 32'(n_ps), 32'd2);
        chk("R3 first addr", 32'(ps_addr[0]), 32'h3D4);
        chk("R3 first data", 32'(ps_data[0]), 32'h34);
        chk("R3 second addr", 32'(ps_addr[1]), 32'h3D5);
        chk("R3 second data", 32'(ps_data[1]), 32'h12);
        chk("R3 latency", 32'(lat), 32'd3);
        acc(12'h408, 2'd2, 1'b1, 32'hDDCC_BBAA);
        chk("R3 word count", 32'(n_ps), 32'd4);
        for (int k = 0; k < 4; k++) begin
            chk("R3 word addr", 32'(ps_addr[k]), 32'h3C8 + 32'(k));
            chk("R3 word data", 32'(ps_data[k]), 32'hAA + 32'(k) * 32'h11);
        end
        chk("R3 word latency", 32'(lat), 32'd5);
    endtask

    task automatic t_leg_read;
        logic [31:0] exp;
        acc(12'h400, 2'd2, 1'b0, 32'd0);
        exp = 32'd0;
        for (int k = 0; k < 4; k++)
            exp[8*k +: 8] = 8'(8'hC0 + 8'(k)) ^ 8'h5A;
        chk("R4 word read", rd, exp);
        chk("R4 read strobes", 32'(n_ps), 32'd4);
        acc(12'h41E, 2'd1, 1'b0, 32'd0);
        chk("R4 half read", rd, 32'h0000_8584);
    endtask

    task automatic t_ext;
        acc(12'h50A, 2'd1, 1'b1, 32'hFFFF_5555);
        chk("R5 strobes", 32'(n_xs), 32'd1);
        chk("R5 is write", 32'(xs_wr), 32'd1);
        chk("R5 index", 32'(xs_idx), 32'd5);
        chk("R5 data", 32'(xs_wd), 32'h5555);
        chk("R5 latency", 32'(lat), 32'd2);
        acc(12'h515, 2'd0, 1'b1, 32'h0000_9A7B);
        chk("R5 byte idx", 32'(xs_idx), 32'd10);
        chk("R5 byte widened", 32'(xs_wd), 32'h9A7B);
        acc(12'h506, 2'd2, 1'b0, 32'd0);
        chk("R6 read", rd, 32'h0000_A003);
        chk("R6 read strobe", 32'(xs_wr), 32'd0);
        @(negedge clk);
        chk("R6 index held", 32'(xreg_index), 32'd3);
    endtask

    task automatic t_xbank;
        acc(12'h600, 2'd2, 1'b0, 32'd0);
        chk("R7 size", rd, 32'd8);
        chk("R12 size unmapped", nrd, 32'd0);
        acc(12'h604, 2'd2, 1'b0, 32'd0);
        chk("R8 little", rd, 32'h1E1E_1E1E);
        acc(12'h604, 2'd2, 1'b1, 32'hBEBE_BEBE);
        chk("R9 set", 32'(big_endian_fb), 32'd1);
        chk("R12 flag stuck", 32'(n_be), 32'd0);
        acc(12'h604, 2'd2, 1'b0, 32'd0);
        chk("R8 big", rd, 32'hBEBE_BEBE);
        acc(12'h604, 2'd2, 1'b1, 32'h1234_5678);
        chk("R9 other ignored", 32'(big_endian_fb), 32'd1);
        acc(12'h604, 2'd2, 1'b1, 32'h1E1E_1E1E);
        chk("R9 clear", 32'(big_endian_fb), 32'd0);
        chk("R12 rev", 32'(n_rev), 32'd1);
        chk("R12 rev full", 32'(revision), 32'd2);
    endtask

    task automatic t_xb_ignore;
        acc(12'h604, 2'd1, 1'b1, 32'hBEBE_BEBE);
        chk("R10 narrow write", 32'(big_endian_fb), 32'd0);
        acc(12'h604, 2'd1, 1'b0, 32'd0);
        chk("R10 narrow read", rd, 32'd0);
        acc(12'h602, 2'd2, 1'b0, 32'd0);
        chk("R10 gap read", rd, 32'd0);
        acc(12'h600, 2'd2, 1'b1, 32'hBEBE_BEBE);
        chk("R10 ro write", 32'(big_endian_fb), 32'd0);
        acc(12'h600, 2'd2, 1'b0, 32'd0);
        chk("R10 size kept", rd, 32'd8);
    endtask

    task automatic t_unmapped;
        acc(12'h000, 2'd2, 1'b0, 32'd0);
        chk("R11 read", rd, 32'd0);
        chk("R11 latency", 32'(lat), 32'd1);
        chk("R11 no strobe", 32'(n_ps + n_xs), 32'd0);
        acc(12'h516, 2'd1, 1'b1, 32'h0000_1111);
        chk("R11 past ext", 32'(n_ps + n_xs), 32'd0);
        acc(12'h3FF, 2'd0, 1'b0, 32'd0);
        chk("R11 below leg", 32'(n_ps), 32'd0);
        acc(12'h604, 2'd2, 1'b0, 32'd0);
        chk("R12 reg1 unmapped", nrd, 32'd0);
        chk("R11 ready after", 32'(req_ready), 32'd0);
        @(negedge clk);
        chk("R11 idle", 32'(req_ready), 32'd1);
    endtask

    initial begin
        #(4 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_leg_byte();
        t_leg_split_write();
        t_leg_read();
        t_ext();
        t_xbank();
        t_xb_ignore();
        t_unmapped();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule